// File: doc/BRIEF.md
# Segmented physical address generator

The block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical byte address. It holds four segment registers: code, data, extra and stack. The segment value is moved up by four bit positions, so every segment base sits on a 16-byte boundary. The offset is then added to that base. Any carry beyond the top address bit is dropped, so addresses wrap around within the 1 MB space.

Each access comes with a kind code. The kind picks the segment register that is used when nothing else is asked for. An override input can name a different register for every kind except instruction fetch, which always uses the code register.

Memory is split into an even byte bank and an odd byte bank. The block decodes the lowest address bit and the byte/word size into two bank enables. It also raises a flag for a word at an odd address, so that the caller can split that word into two transfers.

The segment registers load through a simple write port. Address generation is combinational from the stored values. A register written on one clock edge therefore affects accesses from the next cycle on.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset all four segment registers hold 0000H, so every access kind yields a physical address equal to its offset.
- R2: The physical address equals (segment value × 16) + offset, taken over 20 bits. For example, segment 1000H with offset 2000H gives 12000H, and the low four address bits always equal the low four offset bits.
- R3: A carry out of address bit 19 is discarded. Segment FFFFH with offset 0010H gives 00000H, and with offset FFFFH gives 0FFEFH.
- R4: Kind 0 (instruction fetch) always uses the code register, whatever the override inputs say. For example, code 1400H with offset 1200H gives 15200H.
- R5: Kind 1 (stack through the stack pointer) and kind 2 (stack through the frame pointer) use the stack register by default. For example, stack 2000H with offset 3000H gives 23000H.
- R6: Kind 3 (general data) uses the data register by default, and kind 4 (string destination) uses the extra register by default.
- R7: When `ovrEn` is 1, every kind other than 0 uses the register named by `ovrSel` instead of its default.
- R8: A write with `wrEn`=1 stores `wrData` into the register named by `wrSel` at the clock edge. An access in the same cycle still sees the old value; accesses from the next cycle see the new one. Without a write and with unchanged inputs, the address holds.
- R9: `evenEn` is 1 exactly when physical address bit 0 is 0.
- R10: `oddEn` is 1 when address bit 0 is 1, or when the access is a word (`isWord`=1).
- R11: `misaligned` is 1 exactly for a word access at an odd address. In that case `evenEn`=0 and `oddEn`=1.
- R12: Kind codes 5 to 7 behave as general data: they use the data register by default, and the override applies to them.

Register index encoding, used by both `wrSel` and `ovrSel`: 0 = code, 1 = data, 2 = extra, 3 = stack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Segment register write strobe |
| wrSel | input | 2 | Index of the register to write |
| wrData | input | 16 | Value to write |
| accType | input | 3 | Access kind code |
| ovrEn | input | 1 | Segment override enable |
| ovrSel | input | 2 | Register index used when the override is on |
| offset | input | 16 | Offset within the segment |
| isWord | input | 1 | 1 = word access, 0 = byte access |
| physAddr | output | 20 | Physical byte address |
| evenEn | output | 1 | Even bank enable |
| oddEn | output | 1 | Odd bank enable |
| misaligned | output | 1 | Word access at an odd address |

## Verification
The bench builds the block with its default parameters: 16-bit segments and offsets and a four-bit shift, so the physical address is 20 bits wide. These values put every worked address pair within reach. That includes two different segment:offset pairs that land on 60000H, and the wraparound at the top of the 1 MB space. A stream of random writes, kinds, overrides and offsets then exercises every path through the segment selection against a behavioural model. This includes the unused kind codes and writes that overlap an access in the same cycle.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  typedef enum logic [2:0] {
    ACC_FETCH   = 3'd0,
    ACC_STK_SP  = 3'd1,
    ACC_STK_BP  = 3'd2,
    ACC_DATA    = 3'd3,
    ACC_STR_DST = 3'd4
  } accKind_t;

  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_EXTRA = 2'd2,
    SEG_STACK = 2'd3
  } segId_t;

  localparam int NUM_SEG = 4;

  typedef struct packed {
    logic [1:0] rdIdx;
    logic       wrStb;
    logic [1:0] wrIdx;
    logic       evenEn;
    logic       oddEn;
    logic       misaligned;
  } strobes_t;

endpackage

// File: rtl/seg_addr_ctrl.sv
module seg_addr_ctrl
  import seg_addr_pkg::*;
(
  input  logic [2:0] accType,
  input  logic       ovrEn,
  input  logic [1:0] ovrSel,
  input  logic       offLsb,
  input  logic       isWord,
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  output strobes_t   stb
);

  segId_t defaultSeg;
  logic   isFetch;

  always_comb begin
    unique case (accType)
      ACC_FETCH:   defaultSeg = SEG_CODE;
      ACC_STK_SP:  defaultSeg = SEG_STACK;
      ACC_STK_BP:  defaultSeg = SEG_STACK;
      ACC_STR_DST: defaultSeg = SEG_EXTRA;
      default:     defaultSeg = SEG_DATA;
    endcase
  end

  assign isFetch = (accType == ACC_FETCH);

  always_comb begin
    stb.rdIdx      = (ovrEn && !isFetch) ? ovrSel : defaultSeg;
    stb.wrStb      = wrEn;
    stb.wrIdx      = wrSel;
    // the segment base has zero low bits, so the address LSB is the offset LSB
    stb.evenEn     = ~offLsb;
    stb.oddEn      = offLsb | isWord;
    stb.misaligned = offLsb & isWord;
  end

endmodule

// File: rtl/seg_addr_dp.sv
module seg_addr_dp
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int PA_W = SEG_W + SHIFT
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         stb,
  input  logic [SEG_W-1:0] wrData,
  input  logic [OFF_W-1:0] offset,
  output logic [PA_W-1:0]  physAddr
);

  logic [SEG_W-1:0] segReg [NUM_SEG];
  logic [SEG_W-1:0] segVal;
  logic [PA_W-1:0]  segBase;
  logic [PA_W-1:0]  offExt;

  for (genvar g = 0; g < NUM_SEG; g++) begin : gSeg
    always_ff @(posedge clk) begin
      if (!rstN)
        segReg[g] <= '0;
      else if (stb.wrStb && (stb.wrIdx == g[1:0]))
        segReg[g] <= wrData;
    end
  end

  assign segVal   = segReg[stb.rdIdx];
  assign segBase  = {segVal, {SHIFT{1'b0}}};
  assign offExt   = PA_W'(offset);
  // the sum keeps PA_W bits, so a carry off the top is dropped
  assign physAddr = segBase + offExt;

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int PA_W = SEG_W + SHIFT
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [SEG_W-1:0] wrData,
  input  logic [2:0]       accType,
  input  logic             ovrEn,
  input  logic [1:0]       ovrSel,
  input  logic [OFF_W-1:0] offset,
  input  logic             isWord,
  output logic [PA_W-1:0]  physAddr,
  output logic             evenEn,
  output logic             oddEn,
  output logic             misaligned
);

  strobes_t stb;

  seg_addr_ctrl u_ctrl (
    .accType (accType),
    .ovrEn   (ovrEn),
    .ovrSel  (ovrSel),
    .offLsb  (offset[0]),
    .isWord  (isWord),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .stb     (stb)
  );

  seg_addr_dp #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (wrData),
    .offset   (offset),
    .physAddr (physAddr)
  );

  assign evenEn     = stb.evenEn;
  assign oddEn      = stb.oddEn;
  assign misaligned = stb.misaligned;

endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk #(
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int PA_W  = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [2:0]       accType,
  input logic             ovrEn,
  input logic [1:0]       ovrSel,
  input logic [OFF_W-1:0] offset,
  input logic             isWord,
  input logic [PA_W-1:0]  physAddr,
  input logic             evenEn,
  input logic             oddEn,
  input logic             misaligned
);

  a_r2_low_bits: assert property (@(posedge clk) disable iff (!rstN)
    physAddr[SHIFT-1:0] == offset[SHIFT-1:0]);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(wrEn) && $stable(offset) && $stable(accType) && $stable(ovrEn) && $stable(ovrSel))
      |-> $stable(physAddr));

  a_r9_even_bank: assert property (@(posedge clk) disable iff (!rstN)
    evenEn == !physAddr[0]);

  a_r10_odd_bank: assert property (@(posedge clk) disable iff (!rstN)
    oddEn == (physAddr[0] | isWord));

  a_r11_misaligned: assert property (@(posedge clk) disable iff (!rstN)
    misaligned |-> (isWord && physAddr[0] && !evenEn && oddEn));

endmodule

bind seg_addr_gen seg_addr_chk #(.OFF_W(OFF_W), .SHIFT(SHIFT), .PA_W(PA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .accType    (accType),
  .ovrEn      (ovrEn),
  .ovrSel     (ovrSel),
  .offset     (offset),
  .isWord     (isWord),
  .physAddr   (physAddr),
  .evenEn     (evenEn),
  .oddEn      (oddEn),
  .misaligned (misaligned)
);

// File: tb/sim_seg_addr_gen.sv
`timescale 1ns/1ps
module sim_seg_addr_gen;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [1:0]  wrSel;
  logic [15:0] wrData;
  logic [2:0]  accType;
  logic        ovrEn;
  logic [1:0]  ovrSel;
  logic [15:0] offset;
  logic        isWord;
  logic [19:0] physAddr;
  logic        evenEn, oddEn, misaligned;

  int nChecks = 0;
  int nFail   = 0;
  int segModel [4];
  bit done = 0;

  always #2.5 clk = ~clk;

  seg_addr_gen u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .accType(accType), .ovrEn(ovrEn), .ovrSel(ovrSel), .offset(offset),
    .isWord(isWord), .physAddr(physAddr), .evenEn(evenEn), .oddEn(oddEn),
    .misaligned(misaligned)
  );

  task automatic finishUp();
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      finishUp();
    end
  end

  function automatic int pickSeg(int typ, bit ovr, int osel);
    int idx;
    case (typ)
      0:       idx = 0;
      1, 2:    idx = 3;
      4:       idx = 2;
      default: idx = 1;
    endcase
    if (ovr && typ != 0) idx = osel;
    return idx;
  endfunction

  task automatic step(input bit wr, input int wsel, input int wdata,
                      input int typ, input bit ovr, input int osel,
                      input int off, input bit word, input string tag);
    int expAddr;
    bit expEven, expOdd, expMis;
    @(negedge clk);
    wrEn = wr; wrSel = wsel[1:0]; wrData = wdata[15:0];
    accType = typ[2:0]; ovrEn = ovr; ovrSel = osel[1:0];
    offset = off[15:0]; isWord = word;
    #1;
    expAddr = ((segModel[pickSeg(typ, ovr, osel)] * 16) + off) % (1 << 20);
    expEven = (off % 2) == 0;
    expOdd  = ((off % 2) == 1) || word;
    expMis  = ((off % 2) == 1) && word;
    nChecks++;
    if (physAddr !== expAddr[19:0] || evenEn !== expEven ||
        oddEn !== expOdd || misaligned !== expMis) begin
      nFail++;
      $display("FAIL %s: addr=%05h even=%0b odd=%0b mis=%0b expected addr=%05h even=%0b odd=%0b mis=%0b",
               tag, physAddr, evenEn, oddEn, misaligned,
               expAddr[19:0], expEven, expOdd, expMis);
    end
    @(posedge clk);
    if (wr) segModel[wsel] = wdata;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) segModel[i] = 0;
    rstN = 1'b0; wrEn = 0; wrSel = 0; wrData = 0; accType = 0;
    ovrEn = 0; ovrSel = 0; offset = 0; isWord = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state: every kind gives the bare offset
    for (int t = 0; t < 5; t++) step(0, 0, 0, t, 0, 0, 16'h1234 + t, 0, "R1");

    // R8 write overlapping an access sees the old value, then the new one
    step(1, 0, 16'h1400, 0, 0, 0, 16'h1200, 0, "R8");
    step(0, 0, 0,        0, 0, 0, 16'h1200, 0, "R4");   // 15200H
    step(1, 1, 16'h1000, 3, 0, 0, 16'h2000, 1, "R8");
    step(0, 0, 0,        3, 0, 0, 16'h2000, 1, "R2");   // 12000H
    step(1, 3, 16'h2000, 2, 0, 0, 16'h3000, 0, "R8");
    step(0, 0, 0,        2, 0, 0, 16'h3000, 0, "R5");   // 23000H
    step(0, 0, 0,        1, 0, 0, 16'h0041, 0, "R5");
    step(1, 2, 16'h52B9, 4, 0, 0, 16'hD470, 0, "R8");
    step(0, 0, 0,        4, 0, 0, 16'hD470, 0, "R6");   // 60000H
    step(0, 0, 0,        3, 0, 0, 16'h0003, 0, "R6");
    step(1, 3, 16'h5D27, 0, 0, 0, 16'h0000, 0, "R8");
    step(0, 0, 0,        1, 0, 0, 16'h2D90, 1, "R5");   // 60000H
    // R4 fetch ignores override
    step(0, 0, 0, 0, 1, 3, 16'h0010, 0, "R4");
    step(0, 0, 0, 0, 1, 2, 16'hFFFF, 1, "R4");
    // R7 override
    step(0, 0, 0, 3, 1, 2, 16'hD470, 0, "R7");
    step(0, 0, 0, 1, 1, 0, 16'h0100, 0, "R7");
    step(0, 0, 0, 4, 1, 3, 16'h2D90, 1, "R7");
    // R12 unused kinds
    step(0, 0, 0, 5, 0, 0, 16'h0007, 0, "R12");
    step(0, 0, 0, 6, 0, 0, 16'h0008, 1, "R12");
    step(0, 0, 0, 7, 1, 0, 16'h0009, 0, "R12");
    // R3 wraparound
    step(1, 1, 16'hFFFF, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 3, 0, 0, 16'h0010, 0, "R3");  // 00000H
    step(0, 0, 0, 3, 0, 0, 16'hFFFF, 0, "R3");  // 0FFEFH
    step(1, 1, 16'h3000, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 3, 0, 0, 16'hFFFF, 0, "R2");  // 3FFFFH
    // bank decode corners
    step(0, 0, 0, 3, 0, 0, 16'h0000, 0, "R9");
    step(0, 0, 0, 3, 0, 0, 16'h0001, 0, "R10");
    step(0, 0, 0, 3, 0, 0, 16'h0002, 1, "R10");
    step(0, 0, 0, 3, 0, 0, 16'h0003, 1, "R11");

    // random traffic checked against the model every cycle
    for (int n = 0; n < 400; n++) begin
      int  typ;
      bit  ovr;
      typ = $urandom_range(7);
      ovr = $urandom_range(1);
      step($urandom_range(3) == 0, $urandom_range(3), $urandom_range(16'hFFFF),
           typ, ovr, $urandom_range(3), $urandom_range(16'hFFFF), $urandom_range(1),
           ovr ? "R7" : (typ == 0 ? "R4" : "R2"));
    end

    done = 1;
    finishUp();
  end

endmodule